// File: doc/BRIEF.md
# Reset and Power-State Controller

This block is a synchronous sequencer that walks a microcontroller-class device through its reset tiers and its low-power modes. It has seven states: a full settings reset, a reset that waits for the oscillator to settle, an operation reset, normal run, a light sleep (nap), a deep stop (halt), and a run-side wait that follows wake-up from stop. Every cycle, one fixed six-level priority picks the next state from the pending requests. From highest to lowest, the levels are: full reset, stabilization-wait expiry, operation reset, wake interrupt, stop request, sleep request.

The two external reset pins are active low and pass through a two-flop synchronizer. The software reset, stop, sleep and interrupt inputs come from on-chip logic and are used as they arrive. Releasing the full reset never leads straight to run: the oscillator wait must run out first, and only then does the operation reset end. A built-in down-counter times each wait. It reloads from `wait_cycles` each time a wait state is entered. All pins are plain control levels, and no data stream passes through the block.

Top module: `rpc_ctrl`

## Requirements
- R1: Power-on reset (`por_n` low) places the machine in state code 0 (full reset). A low level on `full_rst_pin_n`, once synchronized, forces code 0 from any state, ahead of every other request. State codes: 0 full reset, 1 wait-reset, 2 operation reset, 3 run, 4 nap, 5 halt, 6 wait-run.
- R2: In code 0, `full_rst_o`=1, `op_rst_o`=1, `pll_en_o`=0 and `core_clk_en_o`=1.
- R3: When the full-reset request drops, the next state is code 1. Code 0 never goes directly to code 2 or code 3.
- R4: In code 1, `op_rst_o`=1, `full_rst_o`=0, `core_clk_en_o`=0, `pll_en_o`=1 and `pin_hiz_o`=0. Operation-reset requests have no effect here.
- R5: Each entry into code 1 or code 6 loads the counter with `wait_cycles`=N. The state lasts N+1 cycles, and the expiry pulse is one cycle wide. Expiry moves code 1 to code 2.
- R6: From code 3 or code 4, a low `op_rst_pin_n` (after synchronization) or `sw_rst_req`=1 leads to code 2. Code 2 holds while any operation-reset request remains and moves to code 3 one cycle after the last one clears. In code 2, `op_rst_o`=1 and `core_clk_en_o`=1.
- R7: In code 3, `stop_req` leads to code 5 and `sleep_req` leads to code 4. If both are high, stop wins. An operation-reset request beats both. In code 3 all reset outputs are 0 and both enables are 1.
- R8: `stop_req` and `sleep_req` have no effect in any state other than code 3.
- R9: In code 4, `core_clk_en_o`=0, and `wake_irq` returns the machine to code 3.
- R10: In code 5, `pll_en_o`=0, `core_clk_en_o`=0 and `pin_hiz_o`=1. `wake_irq` leads to code 6. An operation-reset request leads to code 1.
- R11: In code 6, clocks are gated and `pin_hiz_o` stays 1. Expiry leads to code 3 and clears `pin_hiz_o`, and it wins over an operation-reset request in the same cycle. An operation-reset request without expiry leads to code 1.
- R12: `pin_hiz_o` is set on entering code 5. It stays set through code 0 and clears only on entering code 1 or code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| full_rst_pin_n | input | 1 | External full settings reset pin, active low, asynchronous |
| op_rst_pin_n | input | 1 | External operation reset pin, active low, asynchronous |
| sw_rst_req | input | 1 | Software operation-reset request |
| stop_req | input | 1 | Register-write request to enter stop |
| sleep_req | input | 1 | Register-write request to enter sleep |
| wake_irq | input | 1 | Valid interrupt pending |
| wait_cycles | input | CNT_W | Programmed oscillator stabilization wait |
| full_rst_o | output | 1 | Full settings reset strobe |
| op_rst_o | output | 1 | Operation reset strobe |
| pll_en_o | output | 1 | Main PLL enable |
| core_clk_en_o | output | 1 | Internal clock gate enable |
| pin_hiz_o | output | 1 | External pin high-impedance control |
| state_o | output | 3 | Current state code |

## Verification
The outputs decode the state register directly. Changes on the on-chip request inputs therefore show up one clock edge later, while a pin level change needs three edges: two synchronizer stages plus the state register. A wait state with a programmed value N lasts N+1 cycles and is left on the following edge. The driver pushes each expectation tagged with the cycle it is due in, counting these edges explicitly. The monitor compares the state code, every decoded output and the high-impedance flag on the falling edge of that cycle only. Deliberate checks one and two cycles after a pin change confirm that the old state is still held.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [2:0] {
    ST_FULLRST = 3'd0,
    ST_WAITRST = 3'd1,
    ST_OPRST   = 3'd2,
    ST_RUN     = 3'd3,
    ST_NAP     = 3'd4,
    ST_HALT    = 3'd5,
    ST_WAITRUN = 3'd6
  } pstate_e;

  function automatic logic is_wait(input pstate_e s);
    return (s == ST_WAITRST) || (s == ST_WAITRUN);
  endfunction

endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], din};
  end

  assign dout = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/rpc_stab_timer.sv
module rpc_stab_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign expire = armed_q && active && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
    end else if (!active || expire) begin
      armed_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rpc_fsm.sv
module rpc_fsm
  import rpc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    full_req,
  input  logic    rst_req,
  input  logic    halt_req,
  input  logic    nap_req,
  input  logic    wake_irq,
  input  logic    expire,
  output pstate_e state_q,
  output logic    load_timer,
  output logic    wait_active,
  output logic    hiz_q
);
  pstate_e nxt;

  // Fixed priority: full reset, expiry, op reset, interrupt, stop, sleep
  always_comb begin
    nxt = state_q;
    if (full_req) begin
      nxt = ST_FULLRST;
    end else begin
      unique case (state_q)
        ST_FULLRST: nxt = ST_WAITRST;
        ST_WAITRST: if (expire) nxt = ST_OPRST;
        ST_WAITRUN: begin
          if (expire)       nxt = ST_RUN;
          else if (rst_req) nxt = ST_WAITRST;
        end
        ST_OPRST:   if (!rst_req) nxt = ST_RUN;
        ST_RUN: begin
          if (rst_req)       nxt = ST_OPRST;
          else if (halt_req) nxt = ST_HALT;
          else if (nap_req)  nxt = ST_NAP;
        end
        ST_NAP: begin
          if (rst_req)       nxt = ST_OPRST;
          else if (wake_irq) nxt = ST_RUN;
        end
        ST_HALT: begin
          if (rst_req)       nxt = ST_WAITRST;
          else if (wake_irq) nxt = ST_WAITRUN;
        end
        default:             nxt = ST_FULLRST;
      endcase
    end
  end

  assign load_timer  = is_wait(nxt) && (nxt != state_q);
  assign wait_active = is_wait(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FULLRST;
      hiz_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      if (nxt == ST_HALT)                           hiz_q <= 1'b1;
      else if (nxt == ST_WAITRST || nxt == ST_RUN)  hiz_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rpc_outdec.sv
module rpc_outdec
  import rpc_pkg::*;
(
  input  pstate_e state,
  output logic    full_rst,
  output logic    op_rst,
  output logic    pll_en,
  output logic    clk_en
);
  always_comb begin
    full_rst = 1'b0;
    op_rst   = 1'b0;
    pll_en   = 1'b1;
    clk_en   = 1'b0;
    unique case (state)
      ST_FULLRST: begin full_rst = 1'b1; op_rst = 1'b1; pll_en = 1'b0; clk_en = 1'b1; end
      ST_WAITRST: begin op_rst = 1'b1; end
      ST_OPRST:   begin op_rst = 1'b1; clk_en = 1'b1; end
      ST_RUN:     begin clk_en = 1'b1; end
      ST_HALT:    begin pll_en = 1'b0; end
      default:    begin end
    endcase
  end
endmodule

// File: rtl/rpc_ctrl.sv
module rpc_ctrl
  import rpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             full_rst_pin_n,
  input  logic             op_rst_pin_n,
  input  logic             sw_rst_req,
  input  logic             stop_req,
  input  logic             sleep_req,
  input  logic             wake_irq,
  input  logic [CNT_W-1:0] wait_cycles,
  output logic             full_rst_o,
  output logic             op_rst_o,
  output logic             pll_en_o,
  output logic             core_clk_en_o,
  output logic             pin_hiz_o,
  output logic [2:0]       state_o
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins_sync;
  logic full_req, rst_req, expire, load_timer, wait_active;
  pstate_e state_q;

  rpc_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(por_n),
    .din  ({full_rst_pin_n, op_rst_pin_n}),
    .dout (pins_sync)
  );

  assign full_req = ~pins_sync[1];
  assign rst_req  = ~pins_sync[0] | sw_rst_req;

  rpc_stab_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (por_n),
    .load    (load_timer),
    .load_val(wait_cycles),
    .active  (wait_active),
    .expire  (expire)
  );

  rpc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (por_n),
    .full_req   (full_req),
    .rst_req    (rst_req),
    .halt_req   (stop_req),
    .nap_req    (sleep_req),
    .wake_irq   (wake_irq),
    .expire     (expire),
    .state_q    (state_q),
    .load_timer (load_timer),
    .wait_active(wait_active),
    .hiz_q      (pin_hiz_o)
  );

  rpc_outdec u_dec (
    .state   (state_q),
    .full_rst(full_rst_o),
    .op_rst  (op_rst_o),
    .pll_en  (pll_en_o),
    .clk_en  (core_clk_en_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/rpc_ctrl_sva.sv
module rpc_ctrl_sva
  import rpc_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       full_req,
  input logic       rst_req,
  input logic       expire,
  input logic       full_rst_o,
  input logic       op_rst_o,
  input logic       pll_en_o,
  input logic       core_clk_en_o,
  input logic       pin_hiz_o,
  input logic [2:0] state_o
);
  p_full_wins_r1: assert property (@(posedge clk) disable iff (!por_n)
    full_req |=> state_o == ST_FULLRST);

  p_full_outputs_r2: assert property (@(posedge clk) disable iff (!por_n)
    full_rst_o |-> (op_rst_o && !pll_en_o && core_clk_en_o));

  p_full_exit_r3: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_FULLRST && !full_req) |=> state_o == ST_WAITRST);

  p_wait_rst_r4: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_WAITRST) |-> (op_rst_o && !core_clk_en_o && !pin_hiz_o));

  p_expire_move_r5: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_WAITRST && expire && !full_req) |=> state_o == ST_OPRST);

  p_expire_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> !expire);

  p_oprst_release_r6: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_OPRST && !full_req && !rst_req) |=> state_o == ST_RUN);

  p_halt_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_HALT && $past(state_o) != ST_HALT) |-> $past(state_o) == ST_RUN);

  p_halt_hiz_r10: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_HALT) |-> (pin_hiz_o && !pll_en_o));

  p_waitrun_wins_r11: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == ST_WAITRUN && expire && !full_req) |=> (state_o == ST_RUN && !pin_hiz_o));
endmodule

bind rpc_ctrl rpc_ctrl_sva u_sva (
  .clk          (clk),
  .por_n        (por_n),
  .full_req     (full_req),
  .rst_req      (rst_req),
  .expire       (expire),
  .full_rst_o   (full_rst_o),
  .op_rst_o     (op_rst_o),
  .pll_en_o     (pll_en_o),
  .core_clk_en_o(core_clk_en_o),
  .pin_hiz_o    (pin_hiz_o),
  .state_o      (state_o)
);

// File: tb/rpc_ctrl_tb.sv
module rpc_ctrl_tb;
  localparam int CNT_W = 16;
  localparam logic [2:0] S_FULL = 3'd0, S_WRST = 3'd1, S_OPR = 3'd2, S_RUN = 3'd3,
                         S_NAP = 3'd4, S_HALT = 3'd5, S_WRUN = 3'd6;

  logic clk = 1'b0;
  logic por_n = 1'b1;
  logic full_pin = 1'b1, op_pin = 1'b1;
  logic sw_rst = 1'b0, stop_r = 1'b0, sleep_r = 1'b0, irq = 1'b0;
  logic [CNT_W-1:0] wait_cycles = 16'd3;
  logic full_rst_o, op_rst_o, pll_en_o, core_clk_en_o, pin_hiz_o;
  logic [2:0] state_o;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    int         due;
    logic [2:0] st;
    logic       hiz;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  rpc_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .por_n(por_n), .full_rst_pin_n(full_pin), .op_rst_pin_n(op_pin),
    .sw_rst_req(sw_rst), .stop_req(stop_r), .sleep_req(sleep_r), .wake_irq(irq),
    .wait_cycles(wait_cycles), .full_rst_o(full_rst_o), .op_rst_o(op_rst_o),
    .pll_en_o(pll_en_o), .core_clk_en_o(core_clk_en_o), .pin_hiz_o(pin_hiz_o),
    .state_o(state_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Expected outputs per state, from R2, R4, R6, R7, R9, R10, R11
  function automatic logic [3:0] exp_outs(input logic [2:0] s);
    logic f, o, p, c;
    f = (s == S_FULL);
    o = (s == S_FULL) || (s == S_WRST) || (s == S_OPR);
    p = !((s == S_FULL) || (s == S_HALT));
    c = (s == S_FULL) || (s == S_OPR) || (s == S_RUN);
    return {f, o, p, c};
  endfunction

  // Monitor: compare items on the falling edge of their due cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t it;
      logic [3:0] got, want;
      it = exp_q.pop_front();
      want = exp_outs(it.st);
      got  = {full_rst_o, op_rst_o, pll_en_o, core_clk_en_o};
      n_checks++;
      if (state_o !== it.st || got !== want || pin_hiz_o !== it.hiz) begin
        n_fail++;
        $display("FAIL %s cyc %0d: state=%0d outs=%b hiz=%b expected state=%0d outs=%b hiz=%b",
                 it.tag, cyc, state_o, got, pin_hiz_o, it.st, want, it.hiz);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input logic [2:0] st, input logic hiz, input string tag);
    exp_t it;
    it.due = cyc; it.st = st; it.hiz = hiz; it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : driver
    #3 por_n = 1'b0;
    tick(2);  expect_st(S_FULL, 0, "R1");          // reset state
    por_n = 1'b1;
    tick(1);  expect_st(S_WRST, 0, "R3");          // full release -> wait reset
    tick(3);  expect_st(S_WRST, 0, "R5");          // N=3: 4 cycles
    tick(1);  expect_st(S_OPR,  0, "R5");
    tick(1);  expect_st(S_RUN,  0, "R6");

    // Sleep and ignore-stop-outside-run
    sleep_r = 1; tick(1); expect_st(S_NAP, 0, "R7");
    sleep_r = 0; stop_r = 1; tick(1); expect_st(S_NAP, 0, "R8");
    stop_r = 0; irq = 1; tick(1); expect_st(S_RUN, 0, "R9");
    irq = 0;

    // Stop beats sleep; wake via wait-run
    stop_r = 1; sleep_r = 1; tick(1); expect_st(S_HALT, 1, "R7");
    stop_r = 0; tick(1); expect_st(S_HALT, 1, "R8");
    sleep_r = 0; irq = 1; tick(1); expect_st(S_WRUN, 1, "R10");
    irq = 0; tick(3); expect_st(S_WRUN, 1, "R11");
    tick(1); expect_st(S_RUN, 0, "R11");

    // Software reset beats stop
    sw_rst = 1; stop_r = 1; tick(1); expect_st(S_OPR, 0, "R6");
    stop_r = 0; tick(1); expect_st(S_OPR, 0, "R6");
    sw_rst = 0; tick(1); expect_st(S_RUN, 0, "R6");

    // Operation reset pin, three edges of latency
    op_pin = 0; tick(2); expect_st(S_RUN, 0, "R6");
    tick(1); expect_st(S_OPR, 0, "R6");
    op_pin = 1; tick(2); expect_st(S_OPR, 0, "R6");
    tick(1); expect_st(S_RUN, 0, "R6");

    // Reset from halt goes to wait reset; op reset ignored there
    stop_r = 1; tick(1); expect_st(S_HALT, 1, "R10");
    stop_r = 0; sw_rst = 1; tick(1); expect_st(S_WRST, 0, "R10");
    tick(3); expect_st(S_WRST, 0, "R4");
    tick(1); expect_st(S_OPR, 0, "R5");
    sw_rst = 0; tick(1); expect_st(S_RUN, 0, "R6");

    // Zero wait: expiry beats reset in wait-run
    wait_cycles = 16'd0;
    stop_r = 1; tick(1); expect_st(S_HALT, 1, "R10");
    stop_r = 0; irq = 1; tick(1); expect_st(S_WRUN, 1, "R11");
    irq = 0; sw_rst = 1; tick(1); expect_st(S_RUN, 0, "R11");
    tick(1); expect_st(S_OPR, 0, "R6");
    sw_rst = 0; tick(1); expect_st(S_RUN, 0, "R6");

    // Reset without expiry in wait-run -> wait reset, reloaded
    wait_cycles = 16'd5;
    stop_r = 1; tick(1); expect_st(S_HALT, 1, "R10");
    stop_r = 0; irq = 1; tick(1); expect_st(S_WRUN, 1, "R11");
    irq = 0; sw_rst = 1; tick(1); expect_st(S_WRST, 0, "R11");
    sw_rst = 0; tick(5); expect_st(S_WRST, 0, "R5");
    tick(1); expect_st(S_OPR, 0, "R5");
    tick(1); expect_st(S_RUN, 0, "R6");

    // Full reset from halt keeps high-impedance until wait reset
    wait_cycles = 16'd2;
    stop_r = 1; tick(1); expect_st(S_HALT, 1, "R10");
    stop_r = 0; full_pin = 0; tick(2); expect_st(S_HALT, 1, "R1");
    tick(1); expect_st(S_FULL, 1, "R12");
    tick(3); expect_st(S_FULL, 1, "R2");
    full_pin = 1; tick(2); expect_st(S_FULL, 1, "R3");
    tick(1); expect_st(S_WRST, 0, "R12");
    tick(2); expect_st(S_WRST, 0, "R5");
    tick(1); expect_st(S_OPR, 0, "R5");
    tick(1); expect_st(S_RUN, 0, "R6");

    // Full reset overrides a pending operation reset
    sw_rst = 1; full_pin = 0; tick(1); expect_st(S_OPR, 0, "R6");
    tick(2); expect_st(S_FULL, 0, "R1");
    full_pin = 1; sw_rst = 0; tick(2); expect_st(S_FULL, 0, "R1");
    tick(1); expect_st(S_WRST, 0, "R3");
    tick(2); expect_st(S_WRST, 0, "R4");
    tick(1); expect_st(S_OPR, 0, "R5");
    tick(1); expect_st(S_RUN, 0, "R7");

    tick(2);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule